// File: doc/BRIEF.md
# Serial Command Decoder for a Label-Filtering Receiver

This block is the host-facing command front end of a serial-bus word receiver. A host talks to it over a four-wire SPI link in mode 0: it lowers chip select, clocks in an 8-bit command code, and then either clocks in a write payload or clocks out a read payload. The payload length depends on the command: none, 8, 16, 32 or 256 bits, or an open-ended stream. The block keeps the 16-bit configuration register and the 8-bit receive-clock divisor itself. It turns the other commands into single-cycle strobes toward three neighbours: a 256-entry label acceptance table, a show-ahead receive FIFO, and a status source.

All SPI pins are resynchronised into the system clock, and every action happens on a detected SCK edge. Commands without a payload take effect as soon as the eighth code bit has been taken in, while chip select is still low. Raising chip select ends any command at once. The serial output is a data/enable pair, so the enable low stands for a released line.

Top module: `lblrx_spi_cmd`

## Requirements
- R1: After chip select falls, the first 8 rising SCK edges shift in the command code, MSB first. Raising chip select abandons the command, so a register write cut short leaves that register unchanged. While chip select is high, `spi_so_en` is low.
- R2: Code 10h takes 16 data bits, MSB first, into `ctrl_reg`. Code 0Bh returns `ctrl_reg` MSB first. Its MSB appears on `spi_so` after the first falling SCK edge that follows the eighth code bit.
- R3: Code 07h takes an 8-bit divisor into `clk_div`. `clk_div_ok` is 1 only for the values 01h, 02h, 04h, 08h and 0Ah. Code 0Ch returns the divisor.
- R4: Codes 01h, 02h and 03h take no data. After the eighth code bit, with chip select still low, they raise `mr_pulse`, `lbl_clr_all` or `lbl_set_all` respectively, each for one clock. No two strobes are high in the same cycle.
- R5: Codes 04h and 05h take an 8-bit label address and write 0 (04h) or 1 (05h) to that single table entry.
- R6: Code 06h takes up to 256 bits. Data bit i (counting from 0 at the first data bit) is written to entry FFh-i, so a stream starting 1011 sets FFh, clears FEh, and sets FDh and FCh. Each entry is written as its bit arrives.
- R7: Code 0Dh returns the 256 table entries, from entry FFh down to entry 00h.
- R8: Code 08h returns the head FIFO word (32 bits, MSB first) and pops it. If the FIFO is empty, it returns zeros and does not pop.
- R9: Code 09h returns FIFO words back to back with no gap, popping each one, and returns zeros once the FIFO is empty.
- R10: Code 0Ah returns the 8-bit `status` input, MSB first.
- R11: A master reset (code 01h) empties the FIFO through `mr_pulse`. `ctrl_reg` and `clk_div` keep their values.
- R12: Codes 00h, 0Eh, 0Fh and 11h to FFh cause no strobe and no register change, and `spi_so` stays 0 throughout them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_si | input | 1 | SPI data from host |
| spi_so | output | 1 | SPI data to host |
| spi_so_en | output | 1 | Output enable for `spi_so`; low means released |
| ctrl_reg | output | 16 | Configuration register |
| clk_div | output | 8 | Receive-clock divisor |
| clk_div_ok | output | 1 | Divisor is one of the legal values |
| mr_pulse | output | 1 | Master reset strobe to the FIFO and flags |
| lbl_clr_all | output | 1 | Clear every table entry |
| lbl_set_all | output | 1 | Set every table entry |
| lbl_wr | output | 1 | Single-entry table write strobe |
| lbl_wr_addr | output | 8 | Table write address |
| lbl_wr_val | output | 1 | Table write value |
| lbl_rd_addr | output | 8 | Table read address |
| lbl_rd_data | input | 1 | Table entry at `lbl_rd_addr` |
| fifo_data | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Remove the head word |
| status | input | 8 | Status byte for code 0Ah |

## Verification
The hardest situation to reach is the word boundary of the streaming read. There the shift register reloads on the same falling edge that emits the last bit of the previous word. The FIFO then runs dry mid-stream, so the output must switch to zeros. The bench preloads three random words and clocks out four word times in a single chip-select window, which crosses both boundaries and the point where the FIFO runs dry. A second hard case is a command cut short by chip select. The bench sends a register code with only half its payload, then checks the register at the port and through a read back.

// File: rtl/lblrx_pkg.sv
package lblrx_pkg;
  localparam int OP_W = 8;

  typedef enum logic [1:0] {I_NONE, I_MR, I_CLR, I_SET} imm_e;
  typedef enum logic [2:0] {W_NONE, W_CLR1, W_SET1, W_MAP, W_DIV, W_CTRL} wr_e;
  typedef enum logic [2:0] {R_NONE, R_FIFO1, R_FIFOS, R_STAT, R_CTRL, R_DIV, R_TBL} rd_e;
endpackage

// File: rtl/lblrx_sync.sv
module lblrx_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST_VAL[g];
        q[g] <= RST_VAL[g];
      end else begin
        meta <= d_in[g];
        q[g] <= meta;
      end
    end
  end
endmodule

// File: rtl/lblrx_opdec.sv
module lblrx_opdec
  import lblrx_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output imm_e            imm,
  output wr_e             wr,
  output rd_e             rd
);
  always_comb begin
    imm = I_NONE;
    wr  = W_NONE;
    rd  = R_NONE;
    case (op)
      8'h01: imm = I_MR;
      8'h02: imm = I_CLR;
      8'h03: imm = I_SET;
      8'h04: wr  = W_CLR1;
      8'h05: wr  = W_SET1;
      8'h06: wr  = W_MAP;
      8'h07: wr  = W_DIV;
      8'h08: rd  = R_FIFO1;
      8'h09: rd  = R_FIFOS;
      8'h0A: rd  = R_STAT;
      8'h0B: rd  = R_CTRL;
      8'h0C: rd  = R_DIV;
      8'h0D: rd  = R_TBL;
      8'h10: wr  = W_CTRL;
      default: ;
    endcase
  end
endmodule

// File: rtl/lblrx_spi_cmd.sv
module lblrx_spi_cmd
  import lblrx_pkg::*;
#(
  parameter int CR_W   = 16,
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32,
  parameter int LBL_AW = 8,
  parameter int ST_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic [CR_W-1:0]   ctrl_reg,
  output logic [DIV_W-1:0]  clk_div,
  output logic              clk_div_ok,
  output logic              mr_pulse,
  output logic              lbl_clr_all,
  output logic              lbl_set_all,
  output logic              lbl_wr,
  output logic [LBL_AW-1:0] lbl_wr_addr,
  output logic              lbl_wr_val,
  output logic [LBL_AW-1:0] lbl_rd_addr,
  input  logic              lbl_rd_data,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic [ST_W-1:0]   status
);
  localparam int NLBL  = 1 << LBL_AW;
  localparam int CNT_W = $clog2(NLBL + 2*OP_W) + 1;
  localparam int SH_W  = WORD_W;
  localparam int WC_W  = $clog2(WORD_W);

  // synchronised pins: {si, sck, cs_n}
  logic [2:0] pin_s;
  logic cs_n_s, sck_s, si_s, sck_q;
  lblrx_sync #(.N(3), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rst(rst), .d_in({spi_si, spi_sck, spi_cs_n}), .q(pin_s)
  );
  assign cs_n_s = pin_s[0];
  assign sck_s  = pin_s[1];
  assign si_s   = pin_s[2];

  logic rise, fall;
  assign rise = sck_s & ~sck_q & ~cs_n_s;
  assign fall = ~sck_s & sck_q & ~cs_n_s;

  logic [OP_W-1:0]  op_q, nop;
  logic [CNT_W-1:0] cnt, didx, rbits;
  logic [WC_W-1:0]  wcnt;
  logic [SH_W-1:0]  sh;
  logic             so_q, so_en_q;
  wr_e              wr_q;
  rd_e              rd_q;
  imm_e             dec_imm;
  wr_e              dec_wr;
  rd_e              dec_rd;

  assign nop  = {op_q[OP_W-2:0], si_s};
  assign didx = cnt - CNT_W'(OP_W);

  lblrx_opdec dec_i (.op(nop), .imm(dec_imm), .wr(dec_wr), .rd(dec_rd));

  logic [DIV_W-1:0] div_in;
  logic             div_legal;
  assign div_in    = {sh[DIV_W-2:0], si_s};
  assign div_legal = (div_in == DIV_W'(1)) || (div_in == DIV_W'(2)) ||
                     (div_in == DIV_W'(4)) || (div_in == DIV_W'(8)) ||
                     (div_in == DIV_W'(10));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0; op_q <= '0; cnt <= '0; rbits <= '0; wcnt <= '0;
      sh <= '0; so_q <= 1'b0; so_en_q <= 1'b0; wr_q <= W_NONE; rd_q <= R_NONE;
      ctrl_reg <= '0; clk_div <= '0; clk_div_ok <= 1'b0;
      mr_pulse <= 1'b0; lbl_clr_all <= 1'b0; lbl_set_all <= 1'b0;
      lbl_wr <= 1'b0; lbl_wr_addr <= '0; lbl_wr_val <= 1'b0;
      lbl_rd_addr <= '0; fifo_pop <= 1'b0;
    end else begin
      mr_pulse <= 1'b0; lbl_clr_all <= 1'b0; lbl_set_all <= 1'b0;
      lbl_wr <= 1'b0; fifo_pop <= 1'b0;
      sck_q   <= sck_s;
      so_en_q <= ~cs_n_s;
      if (cs_n_s) begin
        cnt <= '0; rbits <= '0; wcnt <= '0; so_q <= 1'b0;
        wr_q <= W_NONE; rd_q <= R_NONE;
      end else if (rise) begin
        if (cnt < CNT_W'(OP_W)) begin
          op_q <= nop;
          cnt  <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(OP_W - 1)) begin
            wr_q <= dec_wr; rd_q <= dec_rd; rbits <= '0; wcnt <= '0;
            case (dec_imm)
              I_MR:    mr_pulse    <= 1'b1;
              I_CLR:   lbl_clr_all <= 1'b1;
              I_SET:   lbl_set_all <= 1'b1;
              default: ;
            endcase
            case (dec_rd)
              R_FIFO1, R_FIFOS: begin
                sh       <= fifo_empty ? '0 : fifo_data;
                fifo_pop <= ~fifo_empty;
              end
              R_STAT:  sh <= {status,   {(SH_W-ST_W){1'b0}}};
              R_CTRL:  sh <= {ctrl_reg, {(SH_W-CR_W){1'b0}}};
              R_DIV:   sh <= {clk_div,  {(SH_W-DIV_W){1'b0}}};
              R_TBL: begin
                sh          <= '0;
                lbl_rd_addr <= '1;
              end
              default: sh <= '0;
            endcase
          end
        end else begin
          if (cnt != '1) cnt <= cnt + CNT_W'(1);
          case (wr_q)
            W_MAP: if (didx < CNT_W'(NLBL)) begin
              lbl_wr      <= 1'b1;
              lbl_wr_addr <= ~didx[LBL_AW-1:0];
              lbl_wr_val  <= si_s;
            end
            W_CLR1, W_SET1: begin
              sh <= {sh[SH_W-2:0], si_s};
              if (didx == CNT_W'(LBL_AW - 1)) begin
                lbl_wr      <= 1'b1;
                lbl_wr_addr <= {sh[LBL_AW-2:0], si_s};
                lbl_wr_val  <= (wr_q == W_SET1);
              end
            end
            W_DIV: begin
              sh <= {sh[SH_W-2:0], si_s};
              if (didx == CNT_W'(DIV_W - 1)) begin
                clk_div    <= div_in;
                clk_div_ok <= div_legal;
              end
            end
            W_CTRL: begin
              sh <= {sh[SH_W-2:0], si_s};
              if (didx == CNT_W'(CR_W - 1)) ctrl_reg <= {sh[CR_W-2:0], si_s};
            end
            default: ;
          endcase
        end
      end else if (fall && rd_q != R_NONE) begin
        if (rbits != '1) rbits <= rbits + CNT_W'(1);
        if (rd_q == R_TBL) begin
          so_q        <= (rbits < CNT_W'(NLBL)) ? lbl_rd_data : 1'b0;
          lbl_rd_addr <= lbl_rd_addr - LBL_AW'(1);
        end else begin
          so_q <= sh[SH_W-1];
          if (rd_q == R_FIFOS && wcnt == WC_W'(WORD_W - 1)) begin
            wcnt     <= '0;
            sh       <= fifo_empty ? '0 : fifo_data;
            fifo_pop <= ~fifo_empty;
          end else begin
            wcnt <= wcnt + WC_W'(1);
            sh   <= {sh[SH_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign spi_so    = so_q;
  assign spi_so_en = so_en_q;
endmodule

// File: rtl/lblrx_spi_cmd_chk.sv
module lblrx_spi_cmd_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_so_en,
  input logic mr_pulse,
  input logic lbl_clr_all,
  input logic lbl_set_all,
  input logic lbl_wr,
  input logic fifo_pop,
  input logic fifo_empty
);
  p_so_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_so_en);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mr_pulse, lbl_clr_all, lbl_set_all, lbl_wr, fifo_pop}));

  p_mr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mr_pulse |=> !mr_pulse);

  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !$past(fifo_empty));
endmodule

bind lblrx_spi_cmd lblrx_spi_cmd_chk chk_i (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_so_en(spi_so_en),
  .mr_pulse(mr_pulse), .lbl_clr_all(lbl_clr_all), .lbl_set_all(lbl_set_all),
  .lbl_wr(lbl_wr), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty)
);

// File: tb/lblrx_spi_cmd_tb_top.sv
module lblrx_spi_cmd_tb_top;
  localparam int HALF = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic        cs_n, sck, si, so, so_en;
  logic [15:0] ctrl_reg;
  logic [7:0]  clk_div, lbl_wr_addr, lbl_rd_addr, status;
  logic        clk_div_ok, mr_pulse, lbl_clr_all, lbl_set_all, lbl_wr, lbl_wr_val;
  logic        lbl_rd_data, fifo_empty, fifo_pop;
  logic [31:0] fifo_data;

  logic [255:0] tbl = '0;
  logic [31:0]  fifo_mem [64];
  logic [5:0]   head = '0, tail = '0;
  int n_mr = 0, n_clr = 0, n_set = 0, n_wr = 0;
  int checks = 0, errs = 0;

  assign lbl_rd_data = tbl[lbl_rd_addr];
  assign fifo_data   = fifo_mem[head];
  assign fifo_empty  = (head == tail);

  lblrx_spi_cmd dut_i (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_so(so), .spi_so_en(so_en), .ctrl_reg(ctrl_reg), .clk_div(clk_div),
    .clk_div_ok(clk_div_ok), .mr_pulse(mr_pulse), .lbl_clr_all(lbl_clr_all),
    .lbl_set_all(lbl_set_all), .lbl_wr(lbl_wr), .lbl_wr_addr(lbl_wr_addr),
    .lbl_wr_val(lbl_wr_val), .lbl_rd_addr(lbl_rd_addr), .lbl_rd_data(lbl_rd_data),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .status(status)
  );

  always @(posedge clk) begin
    if (mr_pulse)    begin n_mr++; head <= tail; end
    else if (fifo_pop) head <= head + 6'd1;
    if (lbl_clr_all) begin n_clr++; tbl <= '0; end
    if (lbl_set_all) begin n_set++; tbl <= '1; end
    if (lbl_wr)      begin n_wr++;  tbl[lbl_wr_addr] <= lbl_wr_val; end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic spi(input logic [7:0] op, input int n, input logic [255:0] wd,
                     output logic [255:0] rd, input bit hold);
    rd = '0;
    cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < 8; i++) begin
      si = op[7-i]; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      si = wd[n-1-i]; #HALF; rd[n-1-i] = so; sck = 1'b1; #HALF; sck = 1'b0;
    end
    #HALF;
    if (!hold) begin
      cs_n = 1'b1; #(2*HALF);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fifo_mem[tail] = w;
    tail = tail + 6'd1;
  endtask

  function automatic bit legal(input logic [7:0] d);
    return d == 8'h01 || d == 8'h02 || d == 8'h04 || d == 8'h08 || d == 8'h0A;
  endfunction

  initial begin
    logic [255:0] rd, wd, exp_tbl;
    logic [15:0]  ctrl_exp;
    logic [7:0]   divs [8];
    logic [31:0]  w0, w1, w2;
    int b_mr, b_clr, b_set, b_wr;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; status = '0;
    void'($urandom(32'd2024));
    exp_tbl = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);

    chk(ctrl_reg == 16'h0 && clk_div == 8'h0, "R2 reset regs", {ctrl_reg, clk_div}, 0);
    chk(!so_en, "R1 reset so_en", so_en, 0);

    // R2 control register write and read back
    ctrl_exp = '0;
    for (int k = 0; k < 6; k++) begin
      ctrl_exp = 16'($urandom);
      spi(8'h10, 16, 256'(ctrl_exp), rd, 0);
      chk(ctrl_reg == ctrl_exp, "R2 ctrl port", ctrl_reg, ctrl_exp);
      spi(8'h0B, 16, '0, rd, 0);
      chk(rd[15:0] == ctrl_exp, "R2 ctrl readback", rd[15:0], ctrl_exp);
    end

    // R3 divisor legality and read back
    divs = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h0A, 8'h03, 8'h00, 8'($urandom)};
    for (int k = 0; k < 8; k++) begin
      spi(8'h07, 8, 256'(divs[k]), rd, 0);
      chk(clk_div_ok == legal(divs[k]), "R3 div ok", clk_div_ok, legal(divs[k]));
      spi(8'h0C, 8, '0, rd, 0);
      chk(rd[7:0] == divs[k], "R3 div readback", rd[7:0], divs[k]);
    end

    // R1 aborted write
    spi(8'h10, 8, 256'(8'hA5), rd, 0);
    chk(ctrl_reg == ctrl_exp, "R1 abort keeps ctrl", ctrl_reg, ctrl_exp);
    chk(!so_en, "R1 so_en low after cs high", so_en, 0);
    spi(8'h0B, 16, '0, rd, 0);
    chk(rd[15:0] == ctrl_exp, "R1 abort readback", rd[15:0], ctrl_exp);

    // R4 / R11 master reset executes with CS low
    push(32'h11112222); push(32'h33334444);
    b_mr = n_mr;
    spi(8'h01, 0, '0, rd, 1);
    #(4*HALF);
    chk(n_mr == b_mr + 1 && !cs_n, "R4 mr while cs low", n_mr, b_mr + 1);
    cs_n = 1'b1; #(2*HALF);
    spi(8'h08, 32, '0, rd, 0);
    chk(rd[31:0] == 32'h0, "R11 fifo empty after mr", rd[31:0], 0);
    chk(ctrl_reg == ctrl_exp && clk_div == divs[7], "R11 regs kept", {ctrl_reg, clk_div}, {ctrl_exp, divs[7]});

    // R4 clear all / set all, R7 table read
    b_clr = n_clr;
    spi(8'h02, 0, '0, rd, 1);
    #(4*HALF);
    chk(n_clr == b_clr + 1, "R4 clr while cs low", n_clr, b_clr + 1);
    cs_n = 1'b1; #(2*HALF);
    exp_tbl = '0;
    spi(8'h0D, 256, '0, rd, 0);
    chk(rd == exp_tbl, "R7 read cleared table", rd, exp_tbl);
    b_set = n_set;
    spi(8'h03, 0, '0, rd, 1);
    #(4*HALF);
    chk(n_set == b_set + 1, "R4 set while cs low", n_set, b_set + 1);
    cs_n = 1'b1; #(2*HALF);
    exp_tbl = '1;
    spi(8'h0D, 256, '0, rd, 0);
    chk(rd == exp_tbl, "R7 read set table", rd, exp_tbl);

    // R6 whole-table write, descending from FFh
    wd = {4'b1011, 252'($urandom), 220'h0};
    for (int k = 0; k < 7; k++) wd[32*k +: 32] = wd[32*k +: 32] ^ $urandom;
    wd[255:252] = 4'b1011;
    spi(8'h06, 256, wd, rd, 0);
    exp_tbl = wd;
    chk(tbl[255] && !tbl[254] && tbl[253] && tbl[252], "R6 1011 pattern", tbl[255:252], 4'b1011);
    chk(tbl == exp_tbl, "R6 table contents", tbl, exp_tbl);
    spi(8'h0D, 256, '0, rd, 0);
    chk(rd == exp_tbl, "R7 read after map write", rd, exp_tbl);

    // R5 single entry writes
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      bit v;
      a = 8'($urandom);
      v = 1'($urandom);
      if (k == 0) begin a = 8'hFF; v = 1'b0; end
      if (k == 1) begin a = 8'h00; v = 1'b1; end
      spi(v ? 8'h05 : 8'h04, 8, 256'(a), rd, 0);
      exp_tbl[a] = v;
      chk(tbl == exp_tbl, "R5 single entry write", tbl, exp_tbl);
    end
    spi(8'h0D, 256, '0, rd, 0);
    chk(rd == exp_tbl, "R7 read after single writes", rd, exp_tbl);

    // R8 single word read and empty read
    w0 = $urandom;
    push(w0);
    spi(8'h08, 32, '0, rd, 0);
    chk(rd[31:0] == w0, "R8 head word", rd[31:0], w0);
    chk(fifo_empty, "R8 popped", fifo_empty, 1);
    spi(8'h08, 32, '0, rd, 0);
    chk(rd[31:0] == 32'h0, "R8 empty reads zero", rd[31:0], 0);

    // R9 streaming read across word boundaries and past the end
    w0 = $urandom; w1 = $urandom; w2 = $urandom;
    push(w0); push(w1); push(w2);
    spi(8'h09, 128, '0, rd, 0);
    chk(rd[127:0] == {w0, w1, w2, 32'h0}, "R9 stream", rd[127:0], {w0, w1, w2, 32'h0});
    chk(fifo_empty, "R9 drained", fifo_empty, 1);

    // R10 status read
    for (int k = 0; k < 3; k++) begin
      status = 8'($urandom);
      spi(8'h0A, 8, '0, rd, 0);
      chk(rd[7:0] == status, "R10 status", rd[7:0], status);
    end

    // R12 unused codes
    for (int k = 0; k < 6; k++) begin
      logic [7:0] op;
      case (k)
        0: op = 8'h00; 1: op = 8'h0E; 2: op = 8'h0F; 3: op = 8'h11; 4: op = 8'hFF;
        default: op = 8'h11 + 8'($urandom % 200);
      endcase
      b_mr = n_mr; b_clr = n_clr; b_set = n_set; b_wr = n_wr;
      spi(op, 24, 256'($urandom), rd, 0);
      chk(rd[23:0] == 24'h0, "R12 so stays 0", rd[23:0], 0);
      chk(n_mr == b_mr && n_clr == b_clr && n_set == b_set && n_wr == b_wr,
          "R12 no strobes", n_wr, b_wr);
      chk(ctrl_reg == ctrl_exp && tbl == exp_tbl, "R12 state kept", ctrl_reg, ctrl_exp);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule